// File: doc/BRIEF.md
# Stipple fill write engine

This block accelerates filling pixels of an 8-bit-per-pixel framebuffer from a 32-bit bitmap. Software first writes a colour to the engine's register window. It then writes a bitmap. The bus address of that second write selects the first of 32 consecutive pixels. The engine walks the bitmap, most significant bit first, and issues one framebuffer write per cycle for each set bit. Clear bits take no cycles. The framebuffer memory itself sits outside the block and is driven through a simple write port.

When the wide-plane mode is enabled, each selected pixel also receives the colour with its bytes reversed on a 32-bit plane strobe. A command received through the alternate window additionally strobes a control-plane write with that same value. At the end of every operation the engine emits a one-cycle dirty-range report, so that the refresh logic knows which 32 pixels may have changed. While an operation runs, the engine holds off the bus through a ready signal.

Top module: `stipple_fill_engine`

## Requirements
- R1: An accepted bus write with address bit 2 = 0 stores its 32-bit data as the fill colour. It starts nothing: busy stays low and no memory strobe fires.
- R2: An accepted bus write with address bit 2 = 1 starts an operation. The start pixel is bus address bits [PIX_W+2:3], which equals (address >> 3) masked to PIX_W bits. Address bits [2:0] do not affect the start pixel.
- R3: Mask bit 31 targets the start pixel and mask bit 0 targets start+31. Set bits are written in falling bit order, one per cycle, with no cycles spent on clear bits.
- R4: Each pixel write puts colour bits [7:0] on the 8-bit data output.
- R5: When wide mode is on, each pixel write also asserts the 32-bit plane strobe in the same cycle, at the same pixel address, with data {c[7:0],c[15:8],c[23:16],c[31:24]}. When wide mode is off, that strobe never fires.
- R6: A start write with the alternate-window input high also asserts the control-plane strobe together with each 32-bit plane write. Without the alternate window, that strobe stays low.
- R7: Busy is high from the cycle after the start write through the last pixel cycle. Ready is low while busy. A write presented while ready is low is not taken, so a colour offered during an operation leaves the latched colour unchanged.
- R8: An all-zero mask keeps busy high for exactly one cycle and produces no memory strobes.
- R9: The dirty-range valid pulse is high only in the final busy cycle of each operation. It carries the start pixel and the length 32.
- R10: Pixel addresses wrap modulo 2^PIX_W.
- R11: After reset, busy is low, ready is high, no strobe or dirty pulse fires, and the latched colour is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_mode_i | input | 1 | Enables 32-bit plane writes; sampled at command start |
| bus_we_i | input | 1 | Bus write request |
| bus_alt_i | input | 1 | Command arrives through the alternate window (control plane too) |
| bus_addr_i | input | PIX_W+3 | Bus byte address within the window |
| bus_wdata_i | input | 32 | Colour or mask data |
| bus_ready_o | output | 1 | Write accepted this cycle when high |
| busy_o | output | 1 | Operation in progress |
| mem8_we_o | output | 1 | 8-bit plane write strobe |
| pix_addr_o | output | PIX_W | Pixel index for all plane writes |
| mem8_data_o | output | 8 | 8-bit plane write data |
| mem32_we_o | output | 1 | 32-bit plane write strobe |
| ctl_we_o | output | 1 | Control plane write strobe |
| mem32_data_o | output | 32 | Byte-reversed colour for 32-bit and control planes |
| dirty_valid_o | output | 1 | Dirty-range report, one cycle |
| dirty_start_o | output | PIX_W | First pixel of the dirty range |
| dirty_len_o | output | 6 | Dirty range length in pixels |

## Verification
The assertions assume that every bus input is a defined 0 or 1 after reset. They also assume that a sender whose write is stalled may either hold it or withdraw it, and that wide mode only needs to be steady at the moment a command is accepted. The bench changes inputs only on falling clock edges. It offers a stalled colour write during a running operation and withdraws it before ready returns. It changes wide mode only between operations. That lets the bench verify that the colour is unaffected by comparing it with the next fill.

// File: rtl/stip_pkg.sv
package stip_pkg;
  localparam int unsigned MASK_W = 32;
  localparam int unsigned COL_W  = 32;
  localparam int unsigned OFF_W  = $clog2(MASK_W);
  localparam int unsigned LEN_W  = OFF_W + 1;

  typedef enum logic {ST_IDLE, ST_RUN} stip_state_e;
endpackage

// File: rtl/stip_bus_front.sv
module stip_bus_front
  import stip_pkg::*;
#(
  parameter int unsigned PIX_W  = 20,
  parameter int unsigned ADDR_W = PIX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COL_W-1:0]  wdata_i,
  output logic              start_o,
  output logic [PIX_W-1:0]  start_pix_o,
  output logic [COL_W-1:0]  colour_o
);
  logic accept, col_wr;

  assign accept      = we_i && ready_i;
  assign col_wr      = accept && !addr_i[2];
  assign start_o     = accept && addr_i[2];
  assign start_pix_o = addr_i[PIX_W+2:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     colour_o <= '0;
    else if (col_wr) colour_o <= wdata_i;
  end

  assert_colour_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_wr |=> $stable(colour_o));
  assert_start_no_colour_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> colour_o == $past(colour_o));
endmodule

// File: rtl/stip_lead_one.sv
module stip_lead_one
  import stip_pkg::*;
(
  input  logic [MASK_W-1:0] vec_i,
  output logic [OFF_W-1:0]  off_o,
  output logic              any_o,
  output logic              last_o
);
  logic found;

  always_comb begin
    off_o = '0;
    found = 1'b0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (!found && vec_i[i]) begin
        off_o = OFF_W'(MASK_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign any_o  = |vec_i;
  assign last_o = (vec_i & (vec_i - MASK_W'(1))) == '0;
endmodule

// File: rtl/stip_seq.sv
module stip_seq
  import stip_pkg::*;
#(
  parameter int unsigned PIX_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PIX_W-1:0]  start_pix_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              alt_i,
  input  logic              wide_i,
  output logic              busy_o,
  output logic              pix_we_o,
  output logic [PIX_W-1:0]  pix_addr_o,
  output logic              done_o,
  output logic [PIX_W-1:0]  base_o,
  output logic              alt_o,
  output logic              wide_o
);
  stip_state_e      state_q;
  logic [MASK_W-1:0] mask_q, clr;
  logic [OFF_W-1:0]  off;
  logic              any, last;

  stip_lead_one u_lead (
    .vec_i (mask_q),
    .off_o (off),
    .any_o (any),
    .last_o(last)
  );

  assign clr        = {1'b1, {(MASK_W-1){1'b0}}} >> off;
  assign busy_o     = state_q == ST_RUN;
  assign pix_we_o   = busy_o && any;
  assign pix_addr_o = base_o + PIX_W'(off);
  assign done_o     = busy_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      base_o  <= '0;
      alt_o   <= 1'b0;
      wide_o  <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_RUN;
        mask_q  <= mask_i;
        base_o  <= start_pix_i;
        alt_o   <= alt_i;
        wide_o  <= wide_i;
      end
    end else begin
      mask_q <= mask_q & ~clr;
      if (last) state_q <= ST_IDLE;
    end
  end

  assert_one_bit_per_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o && ($countones(mask_q) == $countones($past(mask_q)) - 1));
  assert_done_ends_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_no_start_while_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/stipple_fill_engine.sv
module stipple_fill_engine
  import stip_pkg::*;
#(
  parameter int unsigned PIX_W  = 20,
  localparam int unsigned ADDR_W = PIX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_mode_i,
  input  logic              bus_we_i,
  input  logic              bus_alt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [COL_W-1:0]  bus_wdata_i,
  output logic              bus_ready_o,
  output logic              busy_o,
  output logic              mem8_we_o,
  output logic [PIX_W-1:0]  pix_addr_o,
  output logic [7:0]        mem8_data_o,
  output logic              mem32_we_o,
  output logic              ctl_we_o,
  output logic [COL_W-1:0]  mem32_data_o,
  output logic              dirty_valid_o,
  output logic [PIX_W-1:0]  dirty_start_o,
  output logic [LEN_W-1:0]  dirty_len_o
);
  logic             start, alt_q, wide_q;
  logic [PIX_W-1:0] start_pix;
  logic [COL_W-1:0] colour;

  assign bus_ready_o = !busy_o;

  stip_bus_front #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .ready_i    (bus_ready_o),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .start_o    (start),
    .start_pix_o(start_pix),
    .colour_o   (colour)
  );

  stip_seq #(.PIX_W(PIX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_pix_i(start_pix),
    .mask_i     (bus_wdata_i),
    .alt_i      (bus_alt_i),
    .wide_i     (wide_mode_i),
    .busy_o     (busy_o),
    .pix_we_o   (mem8_we_o),
    .pix_addr_o (pix_addr_o),
    .done_o     (dirty_valid_o),
    .base_o     (dirty_start_o),
    .alt_o      (alt_q),
    .wide_o     (wide_q)
  );

  assign mem8_data_o = colour[7:0];
  assign mem32_we_o  = mem8_we_o && wide_q;
  assign ctl_we_o    = mem32_we_o && alt_q;
  assign dirty_len_o = LEN_W'(MASK_W);

  for (genvar g = 0; g < COL_W / 8; g++) begin : g_swap
    assign mem32_data_o[8*g +: 8] = colour[8*(COL_W/8-1-g) +: 8];
  end

  assert_dirty_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_valid_o |=> !dirty_valid_o);
  assert_write_stalls_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem8_we_o |-> !bus_ready_o);
  assert_wide_with_pixel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem32_we_o |-> mem8_we_o);
  assert_ctl_with_wide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_o |-> mem32_we_o);
  assert_busy_ends_dirty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(dirty_valid_o));
endmodule

// File: tb/sim_stipple_fill_engine.sv
module sim_stipple_fill_engine;
  localparam int unsigned PIX_W = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide = 1'b0, we = 1'b0, alt = 1'b0;
  logic [22:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, busy, m8we, m32we, ctlwe, dval;
  logic [19:0] paddr, dstart;
  logic [7:0]  m8d;
  logic [31:0] m32d;
  logic [5:0]  dlen;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [31:0] lfsr = 32'hACE1_2457;

  always #5 clk = ~clk;

  stipple_fill_engine #(.PIX_W(PIX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide), .bus_we_i(we), .bus_alt_i(alt),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ready_o(ready), .busy_o(busy),
    .mem8_we_o(m8we), .pix_addr_o(paddr), .mem8_data_o(m8d), .mem32_we_o(m32we),
    .ctl_we_o(ctlwe), .mem32_data_o(m32d), .dirty_valid_o(dval),
    .dirty_start_o(dstart), .dirty_len_o(dlen)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap(input logic [31:0] c);
    return {c[7:0], c[15:8], c[23:16], c[31:24]};
  endfunction

  task automatic next_rand(output logic [31:0] v);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    v = lfsr * 32'h9E37_79B1;
  endtask

  // set_col: write colour first; inject: offer a stalled colour write mid-run
  task automatic run_op(input logic [19:0] pix, input logic [31:0] mask, input logic a,
                        input logic w, input bit set_col, input logic [31:0] col, input bit inject);
    int n, k;
    logic [19:0] exp_addr;
    n = $countones(mask);
    k = 0;
    wide = w;
    if (set_col) begin
      @(negedge clk); we = 1'b1; addr = {pix ^ 20'h5A5A5, 3'b011}; wdata = col;
      @(negedge clk); we = 1'b0;
      chk(!busy && !m8we && ready, "R1 colour write starts nothing", {62'd0, busy, m8we}, 64'd0);
    end
    @(negedge clk); we = 1'b1; alt = a; addr = {pix, 3'b111}; wdata = mask;
    @(negedge clk); we = 1'b0; alt = 1'b0;
    chk(busy && !ready, "R7 busy after start", {62'd0, busy, ready}, 64'd2);
    if (mask == 32'd0) begin
      chk(!m8we && !m32we && !ctlwe, "R8 zero mask no strobe", {61'd0, m8we, m32we, ctlwe}, 64'd0);
      chk(dval && dstart == pix && dlen == 6'd32, "R9 dirty on zero mask",
          {dval, dlen, dstart}, {1'b1, 6'd32, pix});
      if (inject) begin we = 1'b1; addr = 23'd0; wdata = ~col; end
      @(negedge clk); we = 1'b0;
      chk(!busy && ready, "R8 one busy cycle", {62'd0, busy, ready}, 64'd1);
    end else begin
      for (int b = 31; b >= 0; b--) begin
        if (mask[b]) begin
          k++;
          exp_addr = pix + 20'(31 - b);
          chk(busy && m8we && paddr == exp_addr, "R3 pixel order/address R10",
              {m8we, paddr}, {1'b1, exp_addr});
          chk(m8d == col[7:0], "R4 byte data", 64'(m8d), 64'(col[7:0]));
          chk(m32we == w && (!w || m32d == swap(col)), "R5 wide plane",
              {m32we, m32d}, {w, swap(col)});
          chk(ctlwe == (w && a), "R6 control plane", 64'(ctlwe), 64'(w && a));
          chk(dval == (k == n) && (!dval || (dstart == pix && dlen == 6'd32)), "R9 dirty pulse",
              {dval, dlen, dstart}, {(k == n), 6'd32, pix});
          if (inject && k == 1) begin we = 1'b1; addr = 23'd0; wdata = ~col; end
          @(negedge clk);
          if (inject && k == 1) we = 1'b0;
        end
      end
      chk(!busy && ready && !m8we && !dval, "R7 idle after last pixel",
          {60'd0, busy, ready, m8we, dval}, 64'd4);
    end
  endtask

  initial begin
    logic [31:0] c, m;
    logic [19:0] p;
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && ready && !m8we && !m32we && !ctlwe && !dval, "R11 reset state",
        {58'd0, busy, ready, m8we, m32we, ctlwe, dval}, 64'd16);
    run_op(20'h00100, 32'h8000_0001, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0); // R11 colour 0
    for (int mode = 0; mode < 4; mode++) begin
      next_rand(c);
      run_op(20'h00040, 32'd0, mode[1], mode[0], 1'b1, c, 1'b0);
      run_op(20'h12345, 32'hFFFF_FFFF, mode[1], mode[0], 1'b1, c, 1'b0);
      for (int b = 0; b < 32; b++) begin
        next_rand(c); next_rand(m);
        run_op(m[19:0], 32'd1 << b, mode[1], mode[0], 1'b1, c, 1'b0);
      end
      for (int r = 0; r < 24; r++) begin
        next_rand(c); next_rand(m); p = c[27:8];
        run_op(p, m, mode[1], mode[0], 1'b1, c, r[0]);
        run_op(p + 20'd64, m ^ 32'h0F0F_F0F0, mode[1], mode[0], 1'b0, c, 1'b0); // R7 colour kept
      end
    end
    next_rand(c);
    run_op(20'hFFFF0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, c, 1'b0); // R10 wrap
    run_op(20'hFFFFF, 32'hC000_0003, 1'b0, 1'b0, 1'b1, c, 1'b1); // R2 top start pixel
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule